// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block resolves the source and destination operands of one instruction for a 16-bit register-oriented processor. It owns a sixteen-entry register file of 16-bit words in which entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word and entry 3 a hardwired zero. The entries from 4 upward are general purpose. A decoder presents a start pulse with a source mode, a destination mode, two register numbers, a byte/word flag and the extension words already taken from the instruction stream. The unit forms effective addresses, reads memory operands over a simple bus and applies post-increment to the named register. It then reports completion with a one-cycle `done` pulse.

The memory bus is a same-cycle read port: while `mem_rd` is high, `mem_addr` is valid and the environment must present the addressed word on `mem_rdata` in that same cycle. Byte addresses are used throughout. A word read returns the 16-bit value at `mem_addr`, and a byte read selects one half of it by the address's lowest bit. Result writing, instruction fetch, flags and interrupts belong to other blocks. A write port lets those blocks load registers.

Top module: `oam_unit`

## Requirements
- R1: While reset is held and after it is released, `done`, `err` and `mem_rd` are 0 and every register reads as zero.
- R2: Mode codes are 0 register, 1 indexed, 2 symbolic, 3 absolute, 4 indirect, 5 post-increment and 6 immediate. When both operands are in register mode, `done` rises in the cycle after `start` with no memory read. The operand value is the register word, or its low byte zero-extended when `byte_op` is 1.
- R3: Register 3 always reads as zero, and writes to it have no effect.
- R4: The effective address is register plus extension word in indexed mode, register 0 plus extension word in symbolic mode, and the extension word itself in absolute mode. This holds for both the source and the destination.
- R5: Indirect and post-increment modes read at the address held in the register. Post-increment then adds 2 to that register for a word access. For a byte access it adds 1, except on registers 0 and 1, which always add 2.
- R6: In immediate mode the source value is the source extension word, low byte zero-extended in byte mode, and no memory read is made for it.
- R7: A byte memory read returns bits 15:8 of `mem_rdata` when the address is odd and bits 7:0 when it is even, zero-extended.
- R8: `done` pulses one cycle after `start` plus one cycle per memory operand. `mem_rd` is high exactly in those extra cycles, and the source read comes first.
- R9: Destination modes 4 to 6 and source mode 7 are illegal. For them, `done` and `err` rise together in the cycle after `start`, no memory read is made and no register changes.
- R10: The destination side sees the source side's post-increment: a destination register or index register equal to the incremented register uses its new value.
- R11: When `wr_en` is 1, `wr_data` is stored in register `wr_idx` at the clock edge. A post-increment of the same register in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving the presented operand fields |
| src_mode | input | 3 | Source addressing mode code |
| src_reg | input | 4 | Source register number |
| dst_mode | input | 3 | Destination addressing mode code |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | 1 for byte data, 0 for word data |
| src_ext | input | 16 | Source extension word |
| dst_ext | input | 16 | Destination extension word |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 16 | Register write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 16 | Memory read data, same cycle as `mem_rd` |
| done | output | 1 | One-cycle pulse when operands are ready |
| err | output | 1 | Illegal mode, valid with `done` |
| src_val | output | 16 | Source operand value, valid with `done` |
| dst_val | output | 16 | Destination operand value, valid with `done` |
| dst_addr | output | 16 | Destination memory address, valid with `done` when `dst_in_mem` |
| dst_in_mem | output | 1 | Destination operand lives in memory, valid with `done` |

## Verification
Each source mode is paired with register, indexed, symbolic and absolute destinations, in both widths, against a memory whose contents are a computed function of the address. A wrong address therefore shows up as a wrong value, and a swapped byte lane shows up at odd addresses. Post-increment is exercised on a general register, on registers 0 and 1 in byte mode, and on the zero register. In each case the register is then read back, which separates the 1-step and 2-step rules. Some cases reuse the incremented register as the destination, which shows whether the destination sees the new value. Illegal combinations carry a post-increment source, so a side effect that leaked through would be visible in the read-back.

// File: rtl/oam_pkg.sv
package oam_pkg;
  localparam int W = 16;
  localparam int H = W / 2;

  typedef logic [W-1:0] word_t;

  typedef enum logic [2:0] {
    AM_REG = 3'd0,
    AM_IDX = 3'd1,
    AM_SYM = 3'd2,
    AM_ABS = 3'd3,
    AM_IND = 3'd4,
    AM_INC = 3'd5,
    AM_IMM = 3'd6,
    AM_BAD = 3'd7
  } am_e;

  // modes that need one bus read
  function automatic logic mode_is_mem(am_e m);
    return (m == AM_IDX) || (m == AM_SYM) || (m == AM_ABS) ||
           (m == AM_IND) || (m == AM_INC);
  endfunction

  // only the first four codes are allowed on the destination side
  function automatic logic dst_legal(am_e m);
    return (m == AM_REG) || (m == AM_IDX) || (m == AM_SYM) || (m == AM_ABS);
  endfunction

  function automatic word_t ea_of(am_e m, word_t rv, word_t pc, word_t ext);
    case (m)
      AM_IDX:         return rv + ext;
      AM_SYM:         return pc + ext;
      AM_ABS:         return ext;
      AM_IND, AM_INC: return rv;
      default:        return '0;
    endcase
  endfunction

  // pointer registers keep word alignment even on byte steps
  function automatic word_t step_of(logic bw, logic keep_even);
    return (bw && !keep_even) ? W'(1) : W'(2);
  endfunction

  function automatic word_t narrow(word_t v, logic bw);
    return bw ? {{(W-H){1'b0}}, v[H-1:0]} : v;
  endfunction

  function automatic word_t lane_pick(word_t addr, word_t data, logic bw);
    if (!bw) return data;
    return addr[0] ? {{(W-H){1'b0}}, data[W-1:H]} : {{(W-H){1'b0}}, data[H-1:0]};
  endfunction
endpackage

// File: rtl/oam_rf.sv
module oam_rf import oam_pkg::*; #(
  parameter int N        = 16,
  parameter int ZERO_IDX = 3,
  localparam int IW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t         wr_data,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_idx,
  input  word_t         inc_step,
  output word_t         q [N]
);
  localparam logic [IW-1:0] ZI = IW'(ZERO_IDX);

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == ZERO_IDX) begin : g_zero
      assign q[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                                  q[g] <= '0;
        else if (inc_en && inc_idx == IW'(g))        q[g] <= q[g] + inc_step;
        else if (wr_en && wr_idx == IW'(g))          q[g] <= wr_data;
      end
    end
  end

  // R5: a post-increment moves the register by exactly the step
  p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && inc_idx != ZI) |=> q[$past(inc_idx)] == $past(q[inc_idx]) + $past(inc_step));

  // R11: an uncontested write lands
  p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != ZI && !(inc_en && inc_idx == wr_idx))
      |=> q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/oam_ea.sv
module oam_ea import oam_pkg::*; (
  input  am_e   mode,
  input  word_t rv,
  input  word_t pc,
  input  word_t ext,
  output word_t ea
);
  assign ea = ea_of(mode, rv, pc, ext);
endmodule

// File: rtl/oam_seq.sv
module oam_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_bad,
  input  logic in_src_mem,
  input  logic in_dst_mem,
  input  logic lat_dst_mem,
  output logic accept,
  output logic ph_src,
  output logic ph_dst,
  output logic ph_done
);
  typedef enum logic [1:0] {S_IDLE, S_SRC, S_DST, S_FIN} st_e;
  st_e st, nx;

  assign accept = start && (st == S_IDLE || st == S_FIN);

  always_comb begin
    nx = st;
    if (accept) begin
      if (in_bad)          nx = S_FIN;
      else if (in_src_mem) nx = S_SRC;
      else if (in_dst_mem) nx = S_DST;
      else                 nx = S_FIN;
    end else begin
      case (st)
        S_SRC:   nx = lat_dst_mem ? S_DST : S_FIN;
        S_DST:   nx = S_FIN;
        S_FIN:   nx = S_IDLE;
        default: nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;
  end

  assign ph_src  = (st == S_SRC);
  assign ph_dst  = (st == S_DST);
  assign ph_done = (st == S_FIN);

  // R8: phases exclusive, each memory phase lasts one cycle, source first
  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph_src, ph_dst, ph_done}));
  p_src_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_src |=> !ph_src);
  p_dst_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_dst |-> ($past(ph_src) || $past(accept)));
  // R9: illegal requests finish at once
  p_bad_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_bad) |=> (ph_done && !ph_src && !ph_dst));
endmodule

// File: rtl/oam_unit.sv
module oam_unit import oam_pkg::*; #(
  parameter int REG_N    = 16,
  parameter int PC_IDX   = 0,
  parameter int SP_IDX   = 1,
  parameter int ZERO_IDX = 3,
  localparam int IW      = $clog2(REG_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    src_mode,
  input  logic [IW-1:0] src_reg,
  input  logic [2:0]    dst_mode,
  input  logic [IW-1:0] dst_reg,
  input  logic          byte_op,
  input  logic [W-1:0]  src_ext,
  input  logic [W-1:0]  dst_ext,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output logic          mem_rd,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic          done,
  output logic          err,
  output logic [W-1:0]  src_val,
  output logic [W-1:0]  dst_val,
  output logic [W-1:0]  dst_addr,
  output logic          dst_in_mem
);
  am_e in_sm, in_dm;
  assign in_sm = am_e'(src_mode);
  assign in_dm = am_e'(dst_mode);

  logic in_bad;
  assign in_bad = (in_sm == AM_BAD) || !dst_legal(in_dm);

  // latched instruction fields
  am_e           l_sm, l_dm;
  logic [IW-1:0] l_sr, l_dr;
  logic          l_bw, l_err;
  word_t         l_sx, l_dx;

  word_t src_q, dst_q, daddr_q;
  word_t q [REG_N];

  logic accept, ph_src, ph_dst, ph_done;

  // named internal events
  logic  inc_en;
  word_t inc_step;
  word_t s_ea, d_ea;
  logic  lat_dst_mem;

  assign lat_dst_mem = mode_is_mem(l_dm);
  assign inc_en      = ph_src && (l_sm == AM_INC);
  assign inc_step    = step_of(l_bw, (l_sr == IW'(PC_IDX)) || (l_sr == IW'(SP_IDX)));

  oam_rf #(.N(REG_N), .ZERO_IDX(ZERO_IDX)) u_rf (
    .clk, .rst_n,
    .wr_en, .wr_idx, .wr_data,
    .inc_en, .inc_idx(l_sr), .inc_step,
    .q
  );

  oam_ea u_src_ea (.mode(l_sm), .rv(q[l_sr]), .pc(q[PC_IDX]), .ext(l_sx), .ea(s_ea));
  oam_ea u_dst_ea (.mode(l_dm), .rv(q[l_dr]), .pc(q[PC_IDX]), .ext(l_dx), .ea(d_ea));

  oam_seq u_seq (
    .clk, .rst_n, .start, .in_bad,
    .in_src_mem(mode_is_mem(in_sm)),
    .in_dst_mem(mode_is_mem(in_dm)),
    .lat_dst_mem,
    .accept, .ph_src, .ph_dst, .ph_done
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_sm    <= AM_REG;
      l_dm    <= AM_REG;
      l_sr    <= '0;
      l_dr    <= '0;
      l_bw    <= 1'b0;
      l_err   <= 1'b0;
      l_sx    <= '0;
      l_dx    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      daddr_q <= '0;
    end else begin
      if (accept) begin
        l_sm    <= in_sm;
        l_dm    <= in_dm;
        l_sr    <= src_reg;
        l_dr    <= dst_reg;
        l_bw    <= byte_op;
        l_err   <= in_bad;
        l_sx    <= src_ext;
        l_dx    <= dst_ext;
        daddr_q <= '0;
        if (in_sm == AM_REG)      src_q <= narrow(q[src_reg], byte_op);
        else if (in_sm == AM_IMM) src_q <= narrow(src_ext, byte_op);
      end
      if (ph_src) src_q <= lane_pick(s_ea, mem_rdata, l_bw);
      if (ph_dst) begin
        dst_q   <= lane_pick(d_ea, mem_rdata, l_bw);
        daddr_q <= d_ea;
      end
    end
  end

  assign mem_rd     = ph_src || ph_dst;
  assign mem_addr   = ph_src ? s_ea : (ph_dst ? d_ea : '0);
  assign done       = ph_done;
  assign err        = ph_done && l_err;
  assign src_val    = src_q;
  // register destination is read live so it sees any post-increment
  assign dst_val    = (l_dm == AM_REG) ? narrow(q[l_dr], l_bw) : dst_q;
  assign dst_addr   = daddr_q;
  assign dst_in_mem = ph_done && lat_dst_mem && !l_err;

  // R2: register-only requests finish next cycle without a bus read
  p_reg_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_bad && !mode_is_mem(in_sm) && !mode_is_mem(in_dm)) |=> (done && !mem_rd));
  // R6: immediate source never reads memory
  p_imm_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_bad && in_sm == AM_IMM) |=> !ph_src);
  // R8: exactly one memory operand costs exactly one extra cycle
  p_one_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_bad && (mode_is_mem(in_sm) != mode_is_mem(in_dm))) |=> mem_rd ##1 done);
  // R9: illegal requests flag an error and stay off the bus
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_bad) |=> (done && err && !mem_rd));
  // R5: an increment happens only while reading at the register's own address
  p_inc_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |-> (mem_rd && mem_addr == q[l_sr]));
endmodule

// File: tb/oam_unit_test.sv
`timescale 1ns/1ps
module oam_unit_test;
  localparam int CLK_HALF = 2;
  localparam int WD_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, byte_op, wr_en;
  logic [2:0]  src_mode, dst_mode;
  logic [3:0]  src_reg, dst_reg, wr_idx;
  logic [15:0] src_ext, dst_ext, wr_data;
  logic        mem_rd, done, err, dst_in_mem;
  logic [15:0] mem_addr, mem_rdata, src_val, dst_val, dst_addr;

  always #CLK_HALF clk = ~clk;

  oam_unit uut (
    .clk, .rst_n, .start, .src_mode, .src_reg, .dst_mode, .dst_reg, .byte_op,
    .src_ext, .dst_ext, .wr_en, .wr_idx, .wr_data,
    .mem_rd, .mem_addr, .mem_rdata,
    .done, .err, .src_val, .dst_val, .dst_addr, .dst_in_mem
  );

  // memory whose content is a function of the address
  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction
  assign mem_rdata = mem_f(mem_addr);

  int n_run = 0, n_fail = 0;
  logic [15:0] m [16];

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(WD_CYC * 2 * CLK_HALF);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  typedef struct packed {
    logic [2:0]  sm;
    logic [3:0]  sr;
    logic [2:0]  dm;
    logic [3:0]  dr;
    logic        bw;
    logic [15:0] sx;
    logic [15:0] dx;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'd4,  3'd0, 4'd5,  1'b0, 16'h0000, 16'h0000},
    '{3'd0, 4'd6,  3'd0, 4'd7,  1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'd3,  3'd0, 4'd0,  1'b0, 16'h0000, 16'h0000},
    '{3'd6, 4'd0,  3'd0, 4'd4,  1'b0, 16'hBEEF, 16'h0000},
    '{3'd6, 4'd0,  3'd1, 4'd5,  1'b1, 16'hBEEF, 16'h0010},
    '{3'd1, 4'd8,  3'd0, 4'd9,  1'b0, 16'h0022, 16'h0000},
    '{3'd2, 4'd0,  3'd3, 4'd0,  1'b1, 16'h0100, 16'h2001},
    '{3'd3, 4'd0,  3'd2, 4'd0,  1'b0, 16'h3004, 16'h0040},
    '{3'd4, 4'd10, 3'd1, 4'd11, 1'b0, 16'h0000, 16'h0004},
    '{3'd5, 4'd12, 3'd0, 4'd13, 1'b0, 16'h0000, 16'h0000},
    '{3'd5, 4'd12, 3'd0, 4'd12, 1'b1, 16'h0000, 16'h0000},
    '{3'd5, 4'd0,  3'd0, 4'd1,  1'b1, 16'h0000, 16'h0000},
    '{3'd5, 4'd1,  3'd1, 4'd1,  1'b1, 16'h0000, 16'h0002},
    '{3'd1, 4'd4,  3'd3, 4'd0,  1'b1, 16'h0001, 16'h0005},
    '{3'd5, 4'd6,  3'd4, 4'd0,  1'b0, 16'h0000, 16'h0000},
    '{3'd7, 4'd2,  3'd0, 4'd2,  1'b0, 16'h0000, 16'h0000},
    '{3'd0, 4'd2,  3'd6, 4'd0,  1'b0, 16'h0000, 16'h0000},
    '{3'd5, 4'd3,  3'd0, 4'd3,  1'b0, 16'h0000, 16'h0000}
  };

  function automatic logic is_mem(input logic [2:0] md);
    return md >= 3'd1 && md <= 3'd5;
  endfunction

  function automatic logic [15:0] ea_m(input logic [2:0] md, input logic [3:0] r, input logic [15:0] x);
    case (md)
      3'd1:       return m[r] + x;
      3'd2:       return m[0] + x;
      3'd3:       return x;
      3'd4, 3'd5: return m[r];
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] rd_m(input logic [15:0] a, input logic bw);
    logic [15:0] d;
    d = mem_f(a);
    if (!bw) return d;
    return a[0] ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd0:    return "R2";
      3'd6:    return "R6";
      3'd4, 3'd5: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic load_regs();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(k); wr_data = 16'h1000 + 16'(k) * 16'h0110;
      m[k] = (k == 3) ? 16'h0000 : 16'h1000 + 16'(k) * 16'h0110;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_op(input vec_t v, output int cyc, output int nrd, output logic [15:0] a0);
    @(negedge clk);
    src_mode = v.sm; src_reg = v.sr; dst_mode = v.dm; dst_reg = v.dr;
    byte_op = v.bw; src_ext = v.sx; dst_ext = v.dx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; nrd = 0; a0 = 16'h0000;
    while (!done && cyc < 10) begin
      if (mem_rd) begin
        if (nrd == 0) a0 = mem_addr;
        nrd++;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic read_reg(input logic [3:0] k, output logic [15:0] val);
    int c, n;
    logic [15:0] a;
    run_op('{3'd0, k, 3'd0, k, 1'b0, 16'h0000, 16'h0000}, c, n, a);
    val = src_val;
  endtask

  initial begin
    int cyc, nrd;
    logic [15:0] a0, rv;
    rst_n = 1'b0; start = 1'b0; byte_op = 1'b0; wr_en = 1'b0;
    src_mode = '0; dst_mode = '0; src_reg = '0; dst_reg = '0;
    src_ext = '0; dst_ext = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 done in reset", 16'(done), 16'h0);
    chk("R1 err in reset", 16'(err), 16'h0);
    chk("R1 mem_rd in reset", 16'(mem_rd), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 16'(done), 16'h0);
    read_reg(4'd5, rv);
    chk("R1 register cleared", rv, 16'h0000);

    // R3: zero register ignores writes
    load_regs();
    read_reg(4'd3, rv);
    chk("R3 zero register after write", rv, 16'h0000);
    // R11: write port
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd7; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0;
    read_reg(4'd7, rv);
    chk("R11 written register", rv, 16'h1234);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic bad, sm_m, dm_m;
      logic [15:0] es, ed, sea, dea;
      int ecyc, enrd;
      v = VECS[i];
      load_regs();
      bad  = (v.sm == 3'd7) || (v.dm > 3'd3);
      sm_m = is_mem(v.sm);
      dm_m = is_mem(v.dm);
      sea  = ea_m(v.sm, v.sr, v.sx);
      if (v.sm == 3'd0)      es = v.bw ? {8'h00, m[v.sr][7:0]} : m[v.sr];
      else if (v.sm == 3'd6) es = v.bw ? {8'h00, v.sx[7:0]} : v.sx;
      else                   es = rd_m(sea, v.bw);
      if (!bad && v.sm == 3'd5 && v.sr != 4'd3)
        m[v.sr] = m[v.sr] + ((v.bw && v.sr > 4'd1) ? 16'd1 : 16'd2);
      dea = ea_m(v.dm, v.dr, v.dx);
      if (v.dm == 3'd0) ed = v.bw ? {8'h00, m[v.dr][7:0]} : m[v.dr];
      else              ed = rd_m(dea, v.bw);
      ecyc = bad ? 1 : 1 + int'(sm_m) + int'(dm_m);
      enrd = bad ? 0 : int'(sm_m) + int'(dm_m);

      run_op(v, cyc, nrd, a0);
      chk($sformatf("R9 err vec %0d", i), 16'(err), 16'(bad));
      chk($sformatf("R8 latency vec %0d", i), 16'(cyc), 16'(ecyc));
      chk($sformatf("R8 read count vec %0d", i), 16'(nrd), 16'(enrd));
      if (!bad) begin
        if (enrd > 0)
          chk($sformatf("%s first read address vec %0d", sm_m ? tag_of(v.sm) : "R4", i),
              a0, sm_m ? sea : dea);
        chk($sformatf("%s%s src_val vec %0d", tag_of(v.sm), (v.bw && sm_m) ? "/R7" : "", i),
            src_val, es);
        chk($sformatf("%s%s dst_val vec %0d", tag_of(v.dm),
                      (v.sm == 3'd5 && v.sr == v.dr) ? "/R10" : "", i), dst_val, ed);
        chk($sformatf("R4 dst_in_mem vec %0d", i), 16'(dst_in_mem), 16'(dm_m));
        if (dm_m)
          chk($sformatf("R4%s dst_addr vec %0d", (v.sm == 3'd5 && v.sr == v.dr) ? "/R10" : "", i),
              dst_addr, dea);
      end
      if (v.sm == 3'd5) begin
        read_reg(v.sr, rv);
        chk($sformatf("%s register after vec %0d", bad ? "R9" : "R5", i), rv, m[v.sr]);
      end
    end

    summary();
    $finish;
  end
endmodule